// File: doc/BRIEF.md
# Partition Read-While-Write Guard

This block sits beside a partitioned flash array and enforces its concurrency rule. A program or erase operation may run in only one partition at a time, while every other partition stays readable. The guard follows write operations through start and finish pulses and records which partition is busy. It decodes every read address against that partition, and it also decodes each sequential step of a burst read. A burst may legally run from one partition into the next. A read or burst step that lands in the busy partition raises a registered conflict flag.

The partition index is the top `PART_BITS` bits of the word address. With the default 24-bit word address and 5 index bits, each partition holds 512K 16-bit words (8 Mbit), and the space holds 16M words. Partition 0 is the parameter partition. The guard does not carry out the write, model array contents or model bus timing.

Write side FSM states: `W_IDLE` and `W_BUSY`. Its transitions are:
- `START` (W_IDLE to W_BUSY, on `wr_start`)
- `FINISH` (W_BUSY to W_IDLE, on `wr_done`)
- `REJECT` (W_BUSY to W_BUSY, on `wr_start` without `wr_done`)

Read side FSM states: `R_IDLE` and `R_BURST`. Its transitions are:
- `LOAD` (any state to R_BURST, on `rd_start`)
- `STEP` (R_BURST to R_BURST, on `rd_next`)
- `CLOSE` (R_BURST to R_IDLE, on `rd_end`)

Top module: `prw_guard`

## Requirements
- R1: After reset the outputs are all zero: `busy`, `busy_part`, `param_busy`, `wr_reject`, `conflict` and `rd_part`.
- R2: The partition of an address is its top `PART_BITS` bits. `param_busy` is high exactly when `busy` is high and `busy_part` is 0, which is the parameter partition.
- R3: `wr_start` in W_IDLE raises `busy` on the next cycle. On that cycle `busy_part` shows the partition of `wr_addr`.
- R4: `wr_done` in W_BUSY drops `busy` on the next cycle and returns `busy_part` to 0. `wr_done` in W_IDLE has no effect.
- R5: `wr_start` in W_BUSY raises `wr_reject` for exactly one cycle, on the next cycle, and leaves `busy_part` unchanged. If `wr_done` arrives in the same cycle, the finish still takes effect and the start is still rejected.
- R6: A checked read address whose partition equals `busy_part` while `busy` is high raises `conflict` on the next cycle. A read of any other partition, or a read while idle, leaves `conflict` low.
- R7: `rd_start` loads a new read address, and each `rd_next` in R_BURST checks the address one above the last. A burst that steps into the busy partition raises `conflict` from its first address inside that partition.
- R8: `rd_next` in R_IDLE and cycles with no read request check nothing: `conflict` stays low and `rd_part` keeps its value. `rd_end` closes the burst. `rd_start` has priority over `rd_end`, and `rd_end` has priority over `rd_next`.
- R9: A burst step from the highest address wraps to address 0, which is in partition 0.
- R10: A read checked in the same cycle as an accepted `wr_start` does not conflict. A read checked in the same cycle as `wr_done` is checked against the partition still busy.
- R11: `rd_part` shows, one cycle later, the partition of the last checked read address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_start | input | 1 | Pulse: program/erase begins at `wr_addr` |
| wr_done | input | 1 | Pulse: current program/erase finished |
| wr_addr | input | ADDR_W | Word address of the write target |
| rd_start | input | 1 | Load a new read address |
| rd_next | input | 1 | Advance the burst by one word |
| rd_end | input | 1 | Close the current burst |
| rd_addr | input | ADDR_W | Read word address, used with `rd_start` |
| busy | output | 1 | A program/erase is in progress |
| busy_part | output | PART_BITS | Index of the busy partition (0 when idle) |
| param_busy | output | 1 | The busy partition is the parameter partition |
| wr_reject | output | 1 | One-cycle pulse: a second write start was refused |
| conflict | output | 1 | Previous checked read hit the busy partition |
| rd_part | output | PART_BITS | Partition of the last checked read address |

## Verification
The bench builds the guard with `ADDR_W = 8` and `PART_BITS = 3`, which gives eight partitions of 32 words. With that size a burst crosses a partition boundary in a few steps, and it can reach the top of the address space and wrap to partition 0 within a short directed test. The index logic is the same slice at any width, so boundary crossings, the wrap and the parameter partition are all exercised at sizes the default build could not reach cheaply.

// File: rtl/prw_pkg.sv
package prw_pkg;
    typedef enum logic {
        W_IDLE = 1'b0,
        W_BUSY = 1'b1
    } wr_state_e;

    typedef enum logic {
        R_IDLE  = 1'b0,
        R_BURST = 1'b1
    } rd_state_e;
endpackage

// File: rtl/prw_part_decode.sv
module prw_part_decode #(
    parameter int ADDR_W    = 24,
    parameter int PART_BITS = 5
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [PART_BITS-1:0] part
);
    localparam int OFF_W = ADDR_W - PART_BITS;

    // offset bits select a word inside the partition and do not matter here
    logic unused_offset;
    assign unused_offset = ^addr[OFF_W-1:0];

    assign part = addr[ADDR_W-1 -: PART_BITS];
endmodule

// File: rtl/prw_write_fsm.sv
module prw_write_fsm
    import prw_pkg::*;
#(
    parameter int PART_BITS = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_start,
    input  logic                 wr_done,
    input  logic [PART_BITS-1:0] start_part,
    output logic                 busy,
    output logic [PART_BITS-1:0] busy_part,
    output logic                 reject
);
    wr_state_e state_q, state_d;
    logic [PART_BITS-1:0] part_q, part_d;
    logic reject_q, reject_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= W_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        part_d   = part_q;
        reject_d = 1'b0;
        unique case (state_q)
            W_IDLE: begin
                if (wr_start) begin
                    state_d = W_BUSY;
                    part_d  = start_part;
                end
            end
            W_BUSY: begin
                reject_d = wr_start;
                if (wr_done) begin
                    state_d = W_IDLE;
                    part_d  = '0;
                end
            end
            default: begin
                state_d = W_IDLE;
                part_d  = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            part_q   <= '0;
            reject_q <= 1'b0;
        end else begin
            part_q   <= part_d;
            reject_q <= reject_d;
        end
    end

    assign busy      = (state_q == W_BUSY);
    assign busy_part = part_q;
    assign reject    = reject_q;
endmodule

// File: rtl/prw_burst_tracker.sv
module prw_burst_tracker
    import prw_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_start,
    input  logic              rd_next,
    input  logic              rd_end,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              chk_valid,
    output logic [ADDR_W-1:0] chk_addr
);
    rd_state_e state_q, state_d;
    logic [ADDR_W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= R_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        chk_valid = 1'b0;
        chk_addr  = held_q;
        if (rd_start) begin
            state_d   = R_BURST;
            chk_valid = 1'b1;
            chk_addr  = rd_addr;
        end else begin
            unique case (state_q)
                R_IDLE: begin
                    state_d = R_IDLE;
                end
                R_BURST: begin
                    if (rd_end) begin
                        state_d = R_IDLE;
                    end else if (rd_next) begin
                        chk_valid = 1'b1;
                        chk_addr  = held_q + 1'b1;
                    end
                end
                default: state_d = R_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (chk_valid) begin
            held_q <= chk_addr;
        end
    end
endmodule

// File: rtl/prw_guard.sv
module prw_guard #(
    parameter int ADDR_W    = 24,
    parameter int PART_BITS = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_start,
    input  logic                 wr_done,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic                 rd_start,
    input  logic                 rd_next,
    input  logic                 rd_end,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic                 busy,
    output logic [PART_BITS-1:0] busy_part,
    output logic                 param_busy,
    output logic                 wr_reject,
    output logic                 conflict,
    output logic [PART_BITS-1:0] rd_part
);
    localparam logic [PART_BITS-1:0] PARAM_IDX = '0;

    logic [PART_BITS-1:0] wr_part;
    logic [PART_BITS-1:0] chk_part;
    logic [ADDR_W-1:0]    chk_addr;
    logic                 chk_valid;
    logic                 conflict_q;
    logic [PART_BITS-1:0] rd_part_q;

    prw_part_decode #(.ADDR_W(ADDR_W), .PART_BITS(PART_BITS)) u_wr_dec (
        .addr (wr_addr),
        .part (wr_part)
    );

    prw_write_fsm #(.PART_BITS(PART_BITS)) u_wr_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_start   (wr_start),
        .wr_done    (wr_done),
        .start_part (wr_part),
        .busy       (busy),
        .busy_part  (busy_part),
        .reject     (wr_reject)
    );

    prw_burst_tracker #(.ADDR_W(ADDR_W)) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_start  (rd_start),
        .rd_next   (rd_next),
        .rd_end    (rd_end),
        .rd_addr   (rd_addr),
        .chk_valid (chk_valid),
        .chk_addr  (chk_addr)
    );

    prw_part_decode #(.ADDR_W(ADDR_W), .PART_BITS(PART_BITS)) u_rd_dec (
        .addr (chk_addr),
        .part (chk_part)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conflict_q <= 1'b0;
            rd_part_q  <= '0;
        end else begin
            conflict_q <= chk_valid && busy && (chk_part == busy_part);
            if (chk_valid) begin
                rd_part_q <= chk_part;
            end
        end
    end

    assign conflict   = conflict_q;
    assign rd_part    = rd_part_q;
    assign param_busy = busy && (busy_part == PARAM_IDX);
endmodule

// File: rtl/prw_guard_chk.sv
module prw_guard_chk #(
    parameter int PART_BITS = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_start,
    input logic                 wr_done,
    input logic                 busy,
    input logic [PART_BITS-1:0] busy_part,
    input logic                 wr_reject,
    input logic                 conflict
);
    // R3
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_start));

    // R4
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(wr_done));

    // R4
    idle_part_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (busy_part == '0));

    // R5
    reject_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reject |-> $past(busy && wr_start));

    // R5
    part_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(busy_part));

    // R6
    conflict_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |-> $past(busy));
endmodule

bind prw_guard prw_guard_chk #(.PART_BITS(PART_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_start  (wr_start),
    .wr_done   (wr_done),
    .busy      (busy),
    .busy_part (busy_part),
    .wr_reject (wr_reject),
    .conflict  (conflict)
);

// File: tb/tb_prw_guard.sv
module tb_prw_guard;
    localparam int AW = 8;
    localparam int PB = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_start = 1'b0, wr_done = 1'b0;
    logic rd_start = 1'b0, rd_next = 1'b0, rd_end = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic busy, param_busy, wr_reject, conflict;
    logic [PB-1:0] busy_part, rd_part;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    prw_guard #(.ADDR_W(AW), .PART_BITS(PB)) dut (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_done(wr_done),
        .wr_addr(wr_addr), .rd_start(rd_start), .rd_next(rd_next),
        .rd_end(rd_end), .rd_addr(rd_addr), .busy(busy), .busy_part(busy_part),
        .param_busy(param_busy), .wr_reject(wr_reject), .conflict(conflict),
        .rd_part(rd_part)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one clock: inputs set after a falling edge, outputs read at the next one
    task automatic cyc();
        @(negedge clk);
        wr_start = 1'b0; wr_done = 1'b0;
        rd_start = 1'b0; rd_next = 1'b0; rd_end = 1'b0;
    endtask

    task automatic idle_write();
        if (busy) begin
            wr_done = 1'b1;
            cyc();
        end
    endtask

    task automatic begin_write(input logic [AW-1:0] a);
        wr_start = 1'b1; wr_addr = a;
        cyc();
    endtask

    task automatic t_reset();
        chk("R1 busy", busy, 0);
        chk("R1 busy_part", busy_part, 0);
        chk("R1 param_busy", param_busy, 0);
        chk("R1 wr_reject", wr_reject, 0);
        chk("R1 conflict", conflict, 0);
        chk("R1 rd_part", rd_part, 0);
    endtask

    task automatic t_start_done();
        begin_write(8'hA7);
        chk("R3 busy", busy, 1);
        chk("R3 busy_part", busy_part, 5);
        chk("R2 param_busy low", param_busy, 0);
        wr_done = 1'b1; cyc();
        chk("R4 busy low", busy, 0);
        chk("R4 part zero", busy_part, 0);
        wr_done = 1'b1; cyc();
        chk("R4 done in idle", busy, 0);
        chk("R4 done in idle reject", wr_reject, 0);
    endtask

    task automatic t_param();
        begin_write(8'h03);
        chk("R2 param part", busy_part, 0);
        chk("R2 param_busy", param_busy, 1);
        idle_write();
        chk("R2 param_busy idle", param_busy, 0);
    endtask

    task automatic t_reject();
        begin_write(8'h45);
        wr_start = 1'b1; wr_addr = 8'hC0; cyc();
        chk("R5 reject pulse", wr_reject, 1);
        chk("R5 part kept", busy_part, 2);
        cyc();
        chk("R5 reject one cycle", wr_reject, 0);
        wr_start = 1'b1; wr_done = 1'b1; wr_addr = 8'hC0; cyc();
        chk("R5 simultaneous reject", wr_reject, 1);
        chk("R5 simultaneous done", busy, 0);
        cyc();
    endtask

    task automatic t_read_conflict();
        begin_write(8'h70);
        rd_start = 1'b1; rd_addr = 8'h65; cyc();
        chk("R6 conflict", conflict, 1);
        chk("R11 rd_part", rd_part, 3);
        cyc();
        chk("R8 no request", conflict, 0);
        rd_start = 1'b1; rd_addr = 8'h45; cyc();
        chk("R6 other partition", conflict, 0);
        chk("R11 rd_part other", rd_part, 2);
        idle_write();
        rd_start = 1'b1; rd_addr = 8'h65; cyc();
        chk("R6 idle read", conflict, 0);
    endtask

    task automatic t_burst_cross();
        begin_write(8'h60);
        rd_start = 1'b1; rd_addr = 8'h5E; cyc();
        chk("R7 start clean", conflict, 0);
        rd_next = 1'b1; cyc();
        chk("R7 step 5F", conflict, 0);
        chk("R7 step 5F part", rd_part, 2);
        rd_next = 1'b1; cyc();
        chk("R7 step into busy", conflict, 1);
        chk("R7 step 60 part", rd_part, 3);
        rd_next = 1'b1; cyc();
        chk("R7 step 61", conflict, 1);
        rd_end = 1'b1; rd_next = 1'b1; cyc();
        chk("R8 end over next", conflict, 0);
        rd_next = 1'b1; cyc();
        chk("R8 next while idle", conflict, 0);
        chk("R8 rd_part kept", rd_part, 3);
        rd_start = 1'b1; rd_end = 1'b1; rd_addr = 8'h20; cyc();
        chk("R8 start over end", rd_part, 1);
        rd_next = 1'b1; cyc();
        chk("R8 burst still open", rd_part, 1);
        idle_write();
    endtask

    task automatic t_wrap();
        begin_write(8'h10);
        rd_start = 1'b1; rd_addr = 8'hFF; cyc();
        chk("R9 top clean", conflict, 0);
        chk("R9 top part", rd_part, 7);
        rd_next = 1'b1; cyc();
        chk("R9 wrap conflict", conflict, 1);
        chk("R9 wrap part", rd_part, 0);
        idle_write();
    endtask

    task automatic t_edges();
        wr_start = 1'b1; wr_addr = 8'h80; rd_start = 1'b1; rd_addr = 8'h85; cyc();
        chk("R10 start cycle busy", busy, 1);
        chk("R10 start cycle no conflict", conflict, 0);
        wr_done = 1'b1; rd_start = 1'b1; rd_addr = 8'h86; cyc();
        chk("R10 done cycle conflict", conflict, 1);
        chk("R10 done cycle idle", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        cyc();
        t_start_done();
        t_param();
        t_reject();
        t_read_conflict();
        t_burst_cross();
        t_wrap();
        t_edges();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule